// File: doc/BRIEF.md
# Minimum Energy Point Tracker

This block steers the digital reference code of an external supply converter toward the voltage at which a load circuit uses the least energy per operation. It assumes that energy per operation, plotted against supply voltage, has a single valley. It sets the reference, waits for the supply to settle, and asks an external sensor for one energy figure. It then compares that figure with the lowest value seen so far and moves the reference by one code. One code is nominally 50 mV.

A run begins with a single-cycle pulse on `trackStart`. The run loads the starting code, clamped into the programmed window, and measures there. It then tries one code higher. While energy keeps falling, it keeps climbing. If the first upward try does not improve, the run turns around and walks downward from one code below the start. The run ends with one corrective step back to the best code found. It then raises `locked` and holds the reference. A system controller or a periodic timer re-issues `trackStart` to follow drift, for example with temperature.

Top module: `mept_tracker`

## Requirements
- R1: While reset is held and after it is released, `refCode` is 0 and `measReq` and `locked` are 0 until the first `trackStart`.
- R2: A `trackStart` pulse loads `refCode` with `initCode` limited to [`minCode`, `maxCode`]. It clears `locked` in the next cycle. The first energy request is made at that loaded code.
- R3: After every change of `refCode`, `measReq` rises exactly `settleCycles`+1 clock cycles after the change.
- R4: `measReq` stays high until a cycle with `measValid` high. `measEnergy` is taken in that same cycle, and `measReq` is low in the following cycle.
- R5: After the first measurement, the code is raised by one. While each new energy is strictly lower than the stored minimum, the minimum is replaced and the code keeps rising by one.
- R6: While rising after an improvement, the first energy that is not lower moves the code down by one and ends the run.
- R7: If the first upward try is not lower, the code jumps to the start code minus one, so the start code is never measured twice. The run then descends one code per measurement. The code never moves by more than two codes per cycle except on a start.
- R8: While descending, the first energy that is not lower moves the code up by one and ends the run.
- R9: An energy equal to the stored minimum counts as not lower.
- R10: `refCode` never leaves [`minCode`, `maxCode`] while measuring. A lower energy measured at a bound ends the run at that bound. A start code at `maxCode` begins by descending.
- R11: Once the run ends, `locked` is 1, `measReq` is 0 and `refCode` is constant until the next `trackStart`.
- R12: A `trackStart` after a locked run starts a complete new run from `initCode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| trackStart | input | 1 | One-cycle pulse that begins (or restarts) a tracking run |
| initCode | input | CODE_W | Starting reference code |
| minCode | input | CODE_W | Lowest permitted reference code |
| maxCode | input | CODE_W | Highest permitted reference code |
| settleCycles | input | SETTLE_W | Wait after each reference change before requesting a measurement |
| measValid | input | 1 | Sensor result valid, one cycle |
| measEnergy | input | ENERGY_W | Energy-per-operation estimate from the sensor |
| measReq | output | 1 | Request for one energy measurement at the current code |
| refCode | output | CODE_W | Reference code to the supply converter |
| locked | output | 1 | Run finished; reference holds the best code found |

## Verification
A wrong stored minimum or a wrong phase does not show at the moment it happens. It shows as a wrong final `refCode` or a wrong number of measurements in the run, or as a code measured twice. Each run is therefore scored on its final code, its measurement count and repeated codes against an energy valley placed by the bench. A broken settle counter shows within one step as the wrong distance between a code change and `measReq`. A stuck request shows as `measReq` dropping before a late sensor answer.

// File: rtl/mept_pkg.sv
package mept_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_MEAS,
    ST_HALT
  } ctlState_t;

  typedef enum logic [1:0] {
    PH_FIRST,
    PH_PROBE,
    PH_CLIMB,
    PH_DESC
  } phase_t;

  typedef struct packed {
    logic loadInit;
    logic stepUp;
    logic stepDown;
    logic stepDownTwo;
    logic storeMin;
    logic settleLoad;
    logic settleTick;
  } dpCmd_t;

endpackage

// File: rtl/mept_datapath.sv
module mept_datapath
  import mept_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int ENERGY_W = 16,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCmd_t              cmd,
  input  logic [CODE_W-1:0]   initCode,
  input  logic [CODE_W-1:0]   minCode,
  input  logic [CODE_W-1:0]   maxCode,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic [ENERGY_W-1:0] measEnergy,
  output logic [CODE_W-1:0]   refCode,
  output logic                atMax,
  output logic                atMin,
  output logic                nearMin,
  output logic                energyLower,
  output logic                settleDone
);

  localparam logic [CODE_W:0]   ONE_EXT = (CODE_W+1)'(1);
  localparam logic [CODE_W-1:0] TWO     = CODE_W'(2);

  logic [CODE_W-1:0]   refQ;
  logic [CODE_W-1:0]   refD;
  logic [CODE_W-1:0]   initClamped;
  logic [CODE_W:0]     minPlusOne;
  logic [ENERGY_W-1:0] minEnergyQ;
  logic [SETTLE_W-1:0] settleQ;

  always_comb begin
    if (initCode < minCode)      initClamped = minCode;
    else if (initCode > maxCode) initClamped = maxCode;
    else                         initClamped = initCode;
  end

  assign minPlusOne  = {1'b0, minCode} + ONE_EXT;
  assign atMax       = (refQ >= maxCode);
  assign atMin       = (refQ <= minCode);
  assign nearMin     = ({1'b0, refQ} <= minPlusOne);
  assign energyLower = (measEnergy < minEnergyQ);
  assign settleDone  = (settleQ == '0);

  always_comb begin
    refD = refQ;
    if (cmd.loadInit)         refD = initClamped;
    else if (cmd.stepUp)      refD = atMax ? refQ : refQ + CODE_W'(1);
    else if (cmd.stepDown)    refD = atMin ? refQ : refQ - CODE_W'(1);
    else if (cmd.stepDownTwo) refD = nearMin ? minCode : refQ - TWO;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refQ       <= '0;
      minEnergyQ <= '1;
      settleQ    <= '0;
    end else begin
      refQ <= refD;
      if (cmd.storeMin) minEnergyQ <= measEnergy;
      if (cmd.settleLoad)                    settleQ <= settleCycles;
      else if (cmd.settleTick && !settleDone) settleQ <= settleQ - SETTLE_W'(1);
    end
  end

  assign refCode = refQ;

endmodule

// File: rtl/mept_control.sv
module mept_control
  import mept_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   trackStart,
  input  logic   measValid,
  input  logic   atMax,
  input  logic   atMin,
  input  logic   nearMin,
  input  logic   energyLower,
  input  logic   settleDone,
  output dpCmd_t cmd,
  output logic   measReq,
  output logic   locked
);

  ctlState_t stateQ, stateD;
  phase_t    phaseQ, phaseD;

  always_comb begin
    cmd    = '0;
    stateD = stateQ;
    phaseD = phaseQ;
    if (trackStart) begin
      cmd.loadInit   = 1'b1;
      cmd.settleLoad = 1'b1;
      stateD         = ST_SETTLE;
      phaseD         = PH_FIRST;
    end else begin
      unique case (stateQ)
        ST_SETTLE: begin
          if (settleDone) stateD = ST_MEAS;
          else            cmd.settleTick = 1'b1;
        end
        ST_MEAS: begin
          if (measValid) begin
            unique case (phaseQ)
              PH_FIRST: begin
                cmd.storeMin = 1'b1;
                if (!atMax) begin
                  cmd.stepUp = 1'b1; cmd.settleLoad = 1'b1;
                  phaseD = PH_PROBE; stateD = ST_SETTLE;
                end else if (!atMin) begin
                  cmd.stepDown = 1'b1; cmd.settleLoad = 1'b1;
                  phaseD = PH_DESC; stateD = ST_SETTLE;
                end else begin
                  stateD = ST_HALT;
                end
              end
              PH_PROBE: begin
                if (energyLower) begin
                  cmd.storeMin = 1'b1;
                  if (atMax) stateD = ST_HALT;
                  else begin
                    cmd.stepUp = 1'b1; cmd.settleLoad = 1'b1;
                    phaseD = PH_CLIMB; stateD = ST_SETTLE;
                  end
                end else begin
                  cmd.stepDownTwo = 1'b1;
                  if (nearMin) stateD = ST_HALT;
                  else begin
                    cmd.settleLoad = 1'b1;
                    phaseD = PH_DESC; stateD = ST_SETTLE;
                  end
                end
              end
              PH_CLIMB: begin
                if (energyLower) begin
                  cmd.storeMin = 1'b1;
                  if (atMax) stateD = ST_HALT;
                  else begin
                    cmd.stepUp = 1'b1; cmd.settleLoad = 1'b1;
                    stateD = ST_SETTLE;
                  end
                end else begin
                  cmd.stepDown = 1'b1;
                  stateD = ST_HALT;
                end
              end
              default: begin
                if (energyLower) begin
                  cmd.storeMin = 1'b1;
                  if (atMin) stateD = ST_HALT;
                  else begin
                    cmd.stepDown = 1'b1; cmd.settleLoad = 1'b1;
                    stateD = ST_SETTLE;
                  end
                end else begin
                  cmd.stepUp = 1'b1;
                  stateD = ST_HALT;
                end
              end
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      phaseQ <= PH_FIRST;
    end else begin
      stateQ <= stateD;
      phaseQ <= phaseD;
    end
  end

  assign measReq = (stateQ == ST_MEAS);
  assign locked  = (stateQ == ST_HALT);

endmodule

// File: rtl/mept_tracker.sv
module mept_tracker
  import mept_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int ENERGY_W = 16,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                trackStart,
  input  logic [CODE_W-1:0]   initCode,
  input  logic [CODE_W-1:0]   minCode,
  input  logic [CODE_W-1:0]   maxCode,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                measValid,
  input  logic [ENERGY_W-1:0] measEnergy,
  output logic                measReq,
  output logic [CODE_W-1:0]   refCode,
  output logic                locked
);

  dpCmd_t cmd;
  logic   atMax, atMin, nearMin, energyLower, settleDone;

  mept_control u_control (
    .clk(clk), .rstN(rstN), .trackStart(trackStart), .measValid(measValid),
    .atMax(atMax), .atMin(atMin), .nearMin(nearMin), .energyLower(energyLower),
    .settleDone(settleDone), .cmd(cmd), .measReq(measReq), .locked(locked)
  );

  mept_datapath #(.CODE_W(CODE_W), .ENERGY_W(ENERGY_W), .SETTLE_W(SETTLE_W)) u_datapath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .initCode(initCode), .minCode(minCode),
    .maxCode(maxCode), .settleCycles(settleCycles), .measEnergy(measEnergy),
    .refCode(refCode), .atMax(atMax), .atMin(atMin), .nearMin(nearMin),
    .energyLower(energyLower), .settleDone(settleDone)
  );

endmodule

// File: rtl/mept_tracker_checker.sv
module mept_tracker_checker #(
  parameter int CODE_W   = 6,
  parameter int SETTLE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                trackStart,
  input logic [CODE_W-1:0]   minCode,
  input logic [CODE_W-1:0]   maxCode,
  input logic [SETTLE_W-1:0] settleCycles,
  input logic                measValid,
  input logic                measReq,
  input logic [CODE_W-1:0]   refCode,
  input logic                locked
);

  logic [CODE_W-1:0]   refPrev;
  logic                startPrev;
  logic [SETTLE_W:0]   sinceChange;
  logic [CODE_W-1:0]   stepMag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPrev     <= '0;
      startPrev   <= 1'b0;
      sinceChange <= '0;
    end else begin
      refPrev   <= refCode;
      startPrev <= trackStart;
      if (refCode != refPrev)  sinceChange <= '0;
      else if (sinceChange != '1) sinceChange <= sinceChange + 1'b1;
    end
  end

  assign stepMag = (refCode >= refPrev) ? refCode - refPrev : refPrev - refCode;

  assert_settle_wait_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(measReq) |-> (sinceChange >= {1'b0, settleCycles}));

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (measReq && !measValid && !trackStart) |=> measReq);

  assert_req_drops_R4: assert property (@(posedge clk) disable iff (!rstN)
    (measReq && measValid && !trackStart) |=> !measReq);

  assert_step_size_R7: assert property (@(posedge clk) disable iff (!rstN)
    !startPrev |-> (stepMag <= CODE_W'(2)));

  assert_in_window_R10: assert property (@(posedge clk) disable iff (!rstN)
    measReq |-> (refCode >= minCode && refCode <= maxCode));

  assert_lock_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !trackStart) |=> (locked && $stable(refCode)));

  assert_lock_no_req_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(locked && measReq));

endmodule

bind mept_tracker mept_tracker_checker #(.CODE_W(CODE_W), .SETTLE_W(SETTLE_W)) u_checker (
  .clk(clk), .rstN(rstN), .trackStart(trackStart), .minCode(minCode), .maxCode(maxCode),
  .settleCycles(settleCycles), .measValid(measValid), .measReq(measReq),
  .refCode(refCode), .locked(locked)
);

// File: tb/mept_tracker_bench.sv
module mept_tracker_bench;

  localparam int CODE_W = 6;
  localparam int ENERGY_W = 16;
  localparam int SETTLE_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trackStart = 1'b0;
  logic [CODE_W-1:0] initCode = '0, minCode = '0, maxCode = '0;
  logic [SETTLE_W-1:0] settleCycles = '0;
  logic measValid = 1'b0;
  logic [ENERGY_W-1:0] measEnergy = '0;
  logic measReq, locked;
  logic [CODE_W-1:0] refCode;

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  mept_tracker u_mept_tracker (
    .clk(clk), .rstN(rstN), .trackStart(trackStart), .initCode(initCode),
    .minCode(minCode), .maxCode(maxCode), .settleCycles(settleCycles),
    .measValid(measValid), .measEnergy(measEnergy), .measReq(measReq),
    .refCode(refCode), .locked(locked)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int energyAt(input int code, input int best, input bit flat);
    if (flat) return 1000;
    return 1000 + (code - best) * (code - best) * 8;
  endfunction

  // Runs one tracking pass, playing the sensor with a valley at code "best".
  task automatic runTrack(input int init, input int lo, input int hi, input int settle,
                          input int best, input bit flat, input int lat,
                          output int finalCode, output int nMeas, output int firstCode,
                          output int firstWait, output int holdErr, output int repeats,
                          output int lockedAfterStart);
    logic [63:0] seen = '0;
    int guard = 0;
    int code;
    nMeas = 0; firstCode = -1; firstWait = 0; holdErr = 0; repeats = 0;
    @(negedge clk);
    initCode = CODE_W'(init); minCode = CODE_W'(lo); maxCode = CODE_W'(hi);
    settleCycles = SETTLE_W'(settle);
    trackStart = 1'b1;
    @(negedge clk);
    trackStart = 1'b0;
    lockedAfterStart = int'(locked);
    while (!measReq && guard < 1000) begin
      firstWait++; guard++;
      @(negedge clk);
    end
    while (!locked && guard < 5000) begin
      guard++;
      if (measReq) begin
        code = int'(refCode);
        if (firstCode < 0) firstCode = code;
        if (seen[code]) repeats++;
        seen[code] = 1'b1;
        nMeas++;
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          if (!measReq) holdErr++;
        end
        measValid = 1'b1;
        measEnergy = ENERGY_W'(energyAt(code, best, flat));
        @(negedge clk);
        measValid = 1'b0;
        if (measReq) holdErr++;
      end else begin
        @(negedge clk);
      end
    end
    finalCode = int'(refCode);
  endtask

  task automatic checkHeld(input string req, input int code);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(locked == 1'b1 && measReq == 1'b0 && int'(refCode) == code, req,
            int'(refCode), code);
    end
  endtask

  task automatic testReset();
    check(refCode == '0, "R1 refCode at reset", int'(refCode), 0);
    check(measReq == 1'b0, "R1 measReq at reset", int'(measReq), 0);
    check(locked == 1'b0, "R1 locked at reset", int'(locked), 0);
  endtask

  task automatic testClimb();
    int f, n, fc, fw, he, rp, la;
    runTrack(20, 10, 50, 2, 24, 1'b0, 0, f, n, fc, fw, he, rp, la);
    check(f == 24, "R5 R6 climb final code", f, 24);
    check(n == 6, "R6 climb measurement count", n, 6);
    check(fc == 20, "R2 first measured code", fc, 20);
    checkHeld("R11 lock holds after climb", 24);
  endtask

  task automatic testDescend();
    int f, n, fc, fw, he, rp, la;
    runTrack(20, 10, 50, 1, 15, 1'b0, 3, f, n, fc, fw, he, rp, la);
    check(f == 15, "R7 R8 descend final code", f, 15);
    check(n == 8, "R8 descend measurement count", n, 8);
    check(rp == 0, "R7 start code not re-measured", rp, 0);
    check(he == 0, "R4 request held until valid", he, 0);
  endtask

  task automatic testAtStart();
    int f, n, fc, fw, he, rp, la;
    runTrack(20, 10, 50, 0, 20, 1'b0, 0, f, n, fc, fw, he, rp, la);
    check(f == 20, "R8 best at start final", f, 20);
    check(n == 3, "R7 best at start count", n, 3);
  endtask

  task automatic testEqual();
    int f, n, fc, fw, he, rp, la;
    runTrack(30, 10, 50, 0, 0, 1'b1, 1, f, n, fc, fw, he, rp, la);
    check(f == 30, "R9 flat energy final", f, 30);
    check(n == 3, "R9 flat energy count", n, 3);
  endtask

  task automatic testUpperBound();
    int f, n, fc, fw, he, rp, la;
    runTrack(45, 10, 50, 0, 60, 1'b0, 0, f, n, fc, fw, he, rp, la);
    check(f == 50, "R10 stop at upper bound", f, 50);
    check(n == 6, "R10 upper bound count", n, 6);
  endtask

  task automatic testLowerBound();
    int f, n, fc, fw, he, rp, la;
    runTrack(14, 10, 50, 0, 2, 1'b0, 0, f, n, fc, fw, he, rp, la);
    check(f == 10, "R10 stop at lower bound", f, 10);
    check(n == 6, "R10 lower bound count", n, 6);
  endtask

  task automatic testInitAtMax();
    int f, n, fc, fw, he, rp, la;
    runTrack(50, 10, 50, 0, 40, 1'b0, 0, f, n, fc, fw, he, rp, la);
    check(f == 40, "R10 start at max descends", f, 40);
    check(n == 12, "R10 start at max count", n, 12);
  endtask

  task automatic testClamp();
    int f, n, fc, fw, he, rp, la;
    runTrack(5, 10, 50, 0, 12, 1'b0, 0, f, n, fc, fw, he, rp, la);
    check(fc == 10, "R2 start code clamped to min", fc, 10);
    check(f == 12, "R2 clamped run final", f, 12);
    check(n == 4, "R2 clamped run count", n, 4);
  endtask

  task automatic testSettle();
    int f, n, fc, fw, he, rp, la;
    runTrack(20, 10, 50, 7, 20, 1'b0, 0, f, n, fc, fw, he, rp, la);
    check(fw == 8, "R3 settle 7 wait cycles", fw, 8);
    runTrack(20, 10, 50, 0, 20, 1'b0, 0, f, n, fc, fw, he, rp, la);
    check(fw == 1, "R3 settle 0 wait cycles", fw, 1);
  endtask

  task automatic testRestart();
    int f, n, fc, fw, he, rp, la;
    runTrack(20, 10, 50, 0, 22, 1'b0, 0, f, n, fc, fw, he, rp, la);
    check(f == 22, "R12 first run final", f, 22);
    runTrack(40, 10, 50, 0, 37, 1'b0, 0, f, n, fc, fw, he, rp, la);
    check(la == 0, "R12 locked cleared on start", la, 0);
    check(fc == 40, "R12 new run starts at init", fc, 40);
    check(f == 37, "R12 second run final", f, 37);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testClimb();
    testDescend();
    testAtStart();
    testEqual();
    testUpperBound();
    testLowerBound();
    testInitAtMax();
    testClamp();
    testSettle();
    testRestart();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule